// File: doc/BRIEF.md
# Multiplexed External Bus Bridge

This block lets a replacement controller reach legacy peripherals that expect the external memory bus of an 8-bit microcontroller. That bus carries the low address byte and the data on the same lines. The host side is a simple request port. It presents an address, a direction, write data and an extended-timing flag for one clock while the bridge is idle. The bridge then plays out one complete bus cycle on the pins. The pins are an address strobe, a data strobe, a read/write line, the high address byte, and the shared address/data byte. The shared byte is split into an output value, an output enable and an input value, and the pad ring merges them.

Every bus cycle is built from timing states. A timing state lasts `STATE_CLKS` host clocks. The default of four matches a host clock running at twice the internal bus clock, with each state spanning two internal clocks. A cycle runs as follows:
- one state with the address driven;
- one state with the address strobe low;
- one state with the address released;
- the data phase, with the data strobe low;
- one recovery state.

The data phase lasts two states. On reads that carry the extended flag it lasts four, which gives slow converter registers time to settle. Writes always use the short form. Read data is captured on the clock edge where the data strobe rises. A one-clock completion pulse marks the end of the access.

Top module: `ext_bus_bridge`

## Requirements
- R1: During and after reset, and whenever no access is in progress, `busy` and `done` are 0, `asN`, `dsN` and `rwN` are 1, and `adOe` is 0.
- R2: While `asN` is low, `adOe` is 1 and `{addrHi, adOut}` equals the requested 16-bit address. `asN` is low for exactly one timing state (`STATE_CLKS` = 4 clocks) per access.
- R3: On a read, `adOe` is 0 for the whole time `dsN` is low, and it is high for only the two address states (8 clocks) of the access.
- R4: On a write, while `dsN` is low, `rwN` is 0, `adOe` is 1 and `adOut` equals the write data. `adOe` is high for 16 clocks in total: two address states and two data states.
- R5: A normal read holds `dsN` low for two timing states (8 clocks). `rdata` takes the value of `adIn` present at the clock edge on which `dsN` returns high.
- R6: A read with `reqExt`=1 holds `dsN` low for four timing states (16 clocks). This lets a device that needs three states of strobe before its data is valid return correct 6-bit values on five consecutive register reads.
- R7: `reqExt` has no effect on writes. A write with `reqExt`=1 keeps `dsN` low for 8 clocks and stays busy for 24 clocks.
- R8: `busy` rises the clock after a request is accepted and stays high for the whole access: 24 clocks normally, 32 clocks for an extended read. A request presented while `busy` is high is ignored and starts no further bus cycle.
- R9: `done` is high for exactly one clock per access, on the last busy clock, and `rdata` already holds the read result in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqExt | input | 1 | Extended data phase for reads |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last captured read data |
| addrHi | output | 8 | High address byte |
| adOut | output | 8 | Shared address/data byte, outgoing value |
| adOe | output | 1 | Drive enable for the shared byte |
| adIn | input | 8 | Shared address/data byte, incoming value |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| rwN | output | 1 | 1 = read, 0 = write |

## Verification
The hardest case to reach from the ports is proving that the extended data phase is actually needed and actually used. Counting strobe clocks alone would not show that the captured byte comes from the late part of the stretched phase. The bench therefore models a slow converter that outputs a junk byte until its data strobe has been low for three states. Reading it with normal timing must return the junk, and five back-to-back extended reads must return each register's 6-bit value. A second awkward case is a request held high for the whole of an access. The bench keeps `reqValid` asserted with a different address until the completion pulse. It then checks that the address seen on the bus was the first one and that no second cycle starts.

// File: rtl/ext_bus_bridge_pkg.sv
package ext_bus_bridge_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ASTB,
    PH_AHOLD,
    PH_DATA,
    PH_END
  } busPhase_t;

  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic asLow;
    logic dsLow;
    logic rwLow;
    logic driveData;
    logic capture;
  } busStrobes_t;

endpackage

// File: rtl/ext_bus_bridge_ctrl.sv
module ext_bus_bridge_ctrl
  import ext_bus_bridge_pkg::*;
#(
  parameter int STATE_CLKS = 4,
  parameter int DS_STATES  = 2,
  parameter int EXT_STATES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        curWrite,
  input  logic        curExt,
  output busStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W  = (STATE_CLKS > 1) ? $clog2(STATE_CLKS) : 1;
  localparam int MAX_ST = DS_STATES + EXT_STATES;
  localparam int ST_W   = $clog2(MAX_ST + 1);

  busPhase_t       phase;
  logic [CNT_W-1:0] clkCnt;
  logic [ST_W-1:0]  stCnt;
  logic [ST_W-1:0]  phaseLen;
  logic             stateEnd;
  logic             phaseEnd;
  logic             stretch;

  // Only reads honour the extended flag.
  assign stretch = curExt && !curWrite;

  always_comb begin
    if (phase == PH_DATA)
      phaseLen = stretch ? ST_W'(MAX_ST) : ST_W'(DS_STATES);
    else
      phaseLen = ST_W'(1);
  end

  assign stateEnd = (clkCnt == CNT_W'(STATE_CLKS - 1));
  assign phaseEnd = stateEnd && (stCnt == phaseLen - ST_W'(1));

  function automatic busPhase_t nextPhase(input busPhase_t p);
    case (p)
      PH_ADDR:  return PH_ASTB;
      PH_ASTB:  return PH_AHOLD;
      PH_AHOLD: return PH_DATA;
      PH_DATA:  return PH_END;
      default:  return PH_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      clkCnt <= '0;
      stCnt  <= '0;
    end else if (phase == PH_IDLE) begin
      clkCnt <= '0;
      stCnt  <= '0;
      if (reqValid) phase <= PH_ADDR;
    end else if (stateEnd) begin
      clkCnt <= '0;
      if (phaseEnd) begin
        stCnt <= '0;
        phase <= nextPhase(phase);
      end else begin
        stCnt <= stCnt + ST_W'(1);
      end
    end else begin
      clkCnt <= clkCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.loadReq   = (phase == PH_IDLE) && reqValid;
    strobes.driveAddr = (phase == PH_ADDR) || (phase == PH_ASTB);
    strobes.asLow     = (phase == PH_ASTB);
    strobes.dsLow     = (phase == PH_DATA);
    strobes.rwLow     = curWrite && (phase != PH_IDLE) && (phase != PH_END);
    strobes.driveData = curWrite && (phase == PH_DATA);
    strobes.capture   = !curWrite && (phase == PH_DATA) && phaseEnd;
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_END) && phaseEnd;

endmodule

// File: rtl/ext_bus_bridge_datapath.sv
module ext_bus_bridge_datapath
  import ext_bus_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobes_t          strobes,
  input  logic                 reqWrite,
  input  logic                 reqExt,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    adIn,
  output logic                 curWrite,
  output logic                 curExt,
  output logic [DATA_W-1:0]    rdata,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]    adOut,
  output logic                 adOe,
  output logic                 asN,
  output logic                 dsN,
  output logic                 rwN
);

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      curWrite <= 1'b0;
      curExt   <= 1'b0;
    end else if (strobes.loadReq) begin
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curWrite <= reqWrite;
      curExt   <= reqExt;
    end
  end

  // Sampled on the edge that ends the data phase, i.e. data strobe rising.
  always_ff @(posedge clk) begin
    if (!rstN)                rdata <= '0;
    else if (strobes.capture) rdata <= adIn;
  end

  assign addrHi = curAddr[ADDR_W-1:DATA_W];
  assign adOut  = strobes.driveData ? curWdata : curAddr[DATA_W-1:0];
  assign adOe   = strobes.driveAddr || strobes.driveData;
  assign asN    = !strobes.asLow;
  assign dsN    = !strobes.dsLow;
  assign rwN    = !strobes.rwLow;

endmodule

// File: rtl/ext_bus_bridge.sv
module ext_bus_bridge
  import ext_bus_bridge_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STATE_CLKS = 4,
  parameter int DS_STATES  = 2,
  parameter int EXT_STATES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqExt,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     asN,
  output logic                     dsN,
  output logic                     rwN
);

  busStrobes_t strobes;
  logic        curWrite;
  logic        curExt;

  ext_bus_bridge_ctrl #(
    .STATE_CLKS(STATE_CLKS),
    .DS_STATES (DS_STATES),
    .EXT_STATES(EXT_STATES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .curWrite(curWrite),
    .curExt  (curExt),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  ext_bus_bridge_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqWrite(reqWrite),
    .reqExt  (reqExt),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .adIn    (adIn),
    .curWrite(curWrite),
    .curExt  (curExt),
    .rdata   (rdata),
    .addrHi  (addrHi),
    .adOut   (adOut),
    .adOe    (adOe),
    .asN     (asN),
    .dsN     (dsN),
    .rwN     (rwN)
  );

endmodule

// File: rtl/ext_bus_bridge_chk.sv
module ext_bus_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic adOe,
  input logic asN,
  input logic dsN,
  input logic rwN
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (asN && dsN && rwN && !adOe && !done));

  // R2
  as_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> (adOe && dsN));

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && rwN) |-> !adOe);

  // R4
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && !rwN) |-> adOe);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && dsN));

endmodule

bind ext_bus_bridge ext_bus_bridge_chk chk_i (
  .clk (clk),
  .rstN(rstN),
  .busy(busy),
  .done(done),
  .adOe(adOe),
  .asN (asN),
  .dsN (dsN),
  .rwN (rwN)
);

// File: tb/ext_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module ext_bus_bridge_tb_top;

  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqExt;
  logic [15:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        busy, done;
  logic [7:0]  rdata, addrHi, adOut, adIn;
  logic        adOe, asN, dsN, rwN;

  ext_bus_bridge dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqExt(reqExt), .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy),
    .done(done), .rdata(rdata), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .asN(asN), .dsN(dsN), .rwN(rwN)
  );

  always #2.5 clk = ~clk;

  int nChk = 0;
  int nBad = 0;

  // Device models
  bit          slowMode = 1'b0;
  logic [15:0] devAddr = '0;
  int          lowCnt = 0;

  always_ff @(posedge clk) begin
    if (!asN) devAddr <= {addrHi, adOut};
    if (dsN) lowCnt <= 0;
    else     lowCnt <= lowCnt + 1;
  end

  function automatic logic [7:0] memVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] adcVal(input logic [15:0] a);
    return {2'b00, a[5:0] ^ 6'h15};
  endfunction

  always_comb begin
    if (!dsN && rwN)
      adIn = slowMode ? ((lowCnt >= 3*S) ? adcVal(devAddr) : 8'hFF) : memVal(devAddr);
    else
      adIn = 8'h5A;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Measurements of one access
  int mBusy, mAs, mDs, mOe, mDone, mAddrBad, mWdBad, mOeRd, mTail;
  logic [7:0] mRdata;
  logic [15:0] mSeenAddr;

  task automatic runAccess(input bit wr, input bit ext, input logic [15:0] a,
                           input logic [7:0] wd, input bit spam);
    bit finished = 1'b0;
    mBusy = 0; mAs = 0; mDs = 0; mOe = 0; mDone = 0;
    mAddrBad = 0; mWdBad = 0; mOeRd = 0; mTail = 0; mRdata = '0; mSeenAddr = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqExt = ext; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    if (spam) begin
      reqAddr = a ^ 16'h0F0F; reqWrite = 1'b0; reqExt = 1'b1;
    end else begin
      reqValid = 1'b0;
    end
    for (int i = 0; i < 2000; i++) begin
      if (!busy) begin finished = 1'b1; break; end
      mBusy++;
      if (!asN) begin
        mAs++;
        mSeenAddr = {addrHi, adOut};
        if ({addrHi, adOut} != a || !adOe) mAddrBad++;
      end
      if (!dsN) begin
        mDs++;
        if (wr && (adOut != wd || !adOe || rwN)) mWdBad++;
        if (!wr && adOe) mOeRd++;
      end
      if (adOe) mOe++;
      if (done) begin mDone++; mRdata = rdata; reqValid = 1'b0; end
      @(negedge clk);
    end
    chk(finished, "access completes", int'(finished), 1);
    reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (busy || !asN || !dsN || adOe) mTail++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    reqValid = 0; reqWrite = 0; reqExt = 0; reqAddr = '0; reqWdata = '0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    chk(!busy && !done && asN && dsN && rwN && !adOe, "R1 reset outputs",
        {busy, done, asN, dsN, rwN, adOe}, 6'b001110);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(!busy && !done && asN && dsN && rwN && !adOe && rdata == 8'h00, "R1 idle outputs",
        {busy, done, asN, dsN, rwN, adOe}, 6'b001110);
  endtask

  task automatic testNormalRead(input logic [15:0] a);
    slowMode = 1'b0;
    runAccess(1'b0, 1'b0, a, 8'h00, 1'b0);
    chk(mAs == S && mAddrBad == 0, "R2 address phase read", mAs, S);
    chk(mOe == 2*S && mOeRd == 0, "R3 read bus release", mOe, 2*S);
    chk(mDs == 2*S, "R5 normal read strobe width", mDs, 2*S);
    chk(mRdata == memVal(a), "R5 read data", mRdata, memVal(a));
    chk(mBusy == 6*S, "R8 normal busy length", mBusy, 6*S);
    chk(mDone == 1, "R9 single done pulse", mDone, 1);
    chk(mTail == 0, "R1 idle after read", mTail, 0);
  endtask

  task automatic testWrite(input bit ext, input logic [15:0] a, input logic [7:0] wd);
    slowMode = 1'b0;
    runAccess(1'b1, ext, a, wd, 1'b0);
    chk(mAs == S && mAddrBad == 0, "R2 address phase write", mAs, S);
    chk(mWdBad == 0 && mOe == 4*S, "R4 write data drive", mOe, 4*S);
    if (ext) begin
      chk(mDs == 2*S, "R7 ext ignored on write strobe", mDs, 2*S);
      chk(mBusy == 6*S, "R7 ext ignored on write length", mBusy, 6*S);
    end else begin
      chk(mDs == 2*S && mBusy == 6*S, "R4 write cycle length", mBusy, 6*S);
    end
    chk(mDone == 1, "R9 write done pulse", mDone, 1);
  endtask

  task automatic testAdcBurst();
    slowMode = 1'b1;
    for (int k = 0; k < 5; k++) begin
      logic [15:0] a = 16'h8020 + 16'(k);
      runAccess(1'b0, 1'b1, a, 8'h00, 1'b0);
      chk(mDs == 4*S, "R6 extended strobe width", mDs, 4*S);
      chk(mBusy == 8*S, "R8 extended busy length", mBusy, 8*S);
      chk(mRdata == adcVal(a), "R6 slow register value", mRdata, adcVal(a));
      chk(mOeRd == 0, "R3 extended read release", mOeRd, 0);
    end
    // Same slow device with normal timing reads too early
    runAccess(1'b0, 1'b0, 16'h8021, 8'h00, 1'b0);
    chk(mRdata == 8'hFF, "R6 normal timing too short for slow device", mRdata, 8'hFF);
    slowMode = 1'b0;
  endtask

  task automatic testBusyIgnore();
    slowMode = 1'b0;
    runAccess(1'b0, 1'b0, 16'h1234, 8'h00, 1'b1);
    chk(mSeenAddr == 16'h1234 && mAs == S, "R8 request while busy ignored (address)",
        mSeenAddr, 16'h1234);
    chk(mBusy == 6*S && mTail == 0, "R8 no second cycle", mTail, 0);
    chk(mRdata == memVal(16'h1234), "R9 data valid with done", mRdata, memVal(16'h1234));
  endtask

  initial begin
    #1_000_000ns;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nBad);
    $finish;
  end

  initial begin
    testReset();
    testNormalRead(16'h0000);
    testNormalRead(16'hA55A);
    testNormalRead(16'hFF01);
    testWrite(1'b0, 16'h2040, 8'hC3);
    testWrite(1'b0, 16'hFFFF, 8'h00);
    testWrite(1'b1, 16'h7E81, 8'h96);
    testAdcBurst();
    testBusyIgnore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule